// File: doc/BRIEF.md
# Attribute Byte Store Controller

This block runs a 256-byte configuration store that sits behind a card-style parallel bus with active-low strobes. A host reaches the store only when the register-space select is low, and only through the even byte lane: word-aligned even addresses on the low eight data bits. Reads return the addressed byte while the read strobes are held. Writes are two-phase. The address and data are captured when the gated write pulse begins. The byte is committed when the first of the write strobe or the low-lane chip enable goes high.

Every committed write opens a self-timed busy window whose length is a parameter in clock cycles. Throughout that window the card ready/busy line is held low, and any new write attempt is dropped. The same line also follows an external busy input from the main memory array. Two further conditions block writes: a protect input, and a lockout window that starts after reset. Reset also produces an inverted reset output for the card. Every bus strobe passes through a synchronizer before it is used in the block clock domain.

Top module: `attr_store_ctrl`

## Requirements
- R1: While reg_n=0, ce1_n=0, ce2_n=1, a0=0 and oe_n=0, rdata_en is 1 and rdata holds the byte stored at addr. In every other case rdata_en is 0 and rdata is all zeros.
- R2: While reg_n=0, an access with a0=1 or with ce2_n=0 neither drives rdata_en nor changes any stored byte.
- R3: With reg_n=1, no read is served and no write changes the store.
- R4: A write stores the value wdata had when reg_n, ce1_n and we_n all became active. A change to wdata later in the same pulse is not stored.
- R5: The store is written, and busy begins, when the first of we_n or ce1_n rises. This takes SYNC_STAGES+1 clock edges after that rise.
- R6: The busy window lasts exactly WR_CYCLES clock cycles. During it rdy_bsy_n is 0.
- R7: A write attempted while busy is ignored.
- R8: rdy_bsy_n is 0 whenever ext_busy_n is 0.
- R9: While wprot is 1, writes are ignored and start no busy window.
- R10: For LOCK_CYCLES cycles after reset is released, writes are ignored.
- R11: rst_out_n is the inverse of rst. Reset ends any busy window at once. Stored bytes survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Active-high reset |
| reg_n | input | 1 | Register-space select, active low |
| ce1_n | input | 1 | Low-lane chip enable, active low |
| ce2_n | input | 1 | High-lane chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Byte address bit 0 (odd byte when 1) |
| addr | input | ADDR_W | Word address selecting the stored byte |
| wdata | input | DATA_W | Low-lane write data |
| rdata | output | DATA_W | Low-lane read data, zero when not driven |
| rdata_en | output | 1 | Drive enable for the low data lane |
| wprot | input | 1 | Write protect, active high |
| ext_busy_n | input | 1 | Busy from the main memory array, active low |
| rdy_bsy_n | output | 1 | Card ready (1) or busy (0) |
| rst_out_n | output | 1 | Inverted reset to the card |

## Verification
The bench samples ready/busy on the exact first and last cycles of the busy window, and again on the cycle after it. A design with an off-by-one timer, or one that commits on the leading edge of the pulse, fails there. It flips the write data in the middle of a pulse, which catches a design that latches data at the trailing edge. It issues a second write inside the busy window, and writes under protect and just after a reset, where a design that ignores those gates would overwrite a byte that is later read back. Random mixes of odd-lane, wrong-space and high-lane accesses check that such cycles neither drive the lane nor store anything.

// File: rtl/attr_store_pkg.sv
package attr_store_pkg;

   // Bus strobes as seen after synchronization; 1 = inactive for the *_n fields.
   typedef struct packed {
      logic reg_n;
      logic ce1_n;
      logic ce2_n;
      logic oe_n;
      logic we_n;
      logic a0;
   } strobe_t;

   localparam int STB_W = $bits(strobe_t);

   // Register space, low lane only, even byte, no high-lane enable.
   function automatic logic lane_ok(strobe_t s);
      return ~s.reg_n & ~s.ce1_n & s.ce2_n & ~s.a0;
   endfunction

endpackage

// File: rtl/attr_sync.sv
module attr_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("attr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("attr_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/attr_array.sv
module attr_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   // Contents are not reset: they persist across reset like a nonvolatile store.
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/attr_write_ctrl.sv
module attr_write_ctrl #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int WR_CYCLES   = 500000,
   parameter int LOCK_CYCLES = 150000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_active,   // gated write pulse present
   input  logic              wr_release,  // we_n or ce1_n high
   input  logic              wprot,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              busy
);

   localparam int WCNT_W = $clog2(WR_CYCLES + 1);
   localparam int LCNT_W = $clog2(LOCK_CYCLES + 1);

   if (WR_CYCLES < 1) begin : g_bad_wr
      $error("attr_write_ctrl: WR_CYCLES must be at least 1");
   end
   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("attr_write_ctrl: LOCK_CYCLES must be at least 1");
   end

   logic              act_q, armed_q, busy_q, lock_q;
   logic [WCNT_W-1:0] wcnt_q;
   logic [LCNT_W-1:0] lcnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              lead, arm, commit;

   assign lead   = wr_active & ~act_q;
   assign arm    = lead & ~armed_q & ~busy_q & ~lock_q & ~wprot;
   assign commit = armed_q & wr_release;

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q   <= 1'b0;
         armed_q <= 1'b0;
         busy_q  <= 1'b0;
         wcnt_q  <= '0;
         lock_q  <= 1'b1;
         lcnt_q  <= '0;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         act_q <= wr_active;

         if (commit) begin
            armed_q <= 1'b0;
         end else if (arm) begin
            armed_q <= 1'b1;
            addr_q  <= addr_i;
            data_q  <= data_i;
         end

         if (commit) begin
            busy_q <= 1'b1;
            wcnt_q <= WCNT_W'(WR_CYCLES - 1);
         end else if (busy_q) begin
            if (wcnt_q == '0) busy_q <= 1'b0;
            else              wcnt_q <= wcnt_q - 1'b1;
         end

         if (lock_q) begin
            if (lcnt_q == LCNT_W'(LOCK_CYCLES - 1)) lock_q <= 1'b0;
            else                                    lcnt_q <= lcnt_q + 1'b1;
         end
      end
   end

   assign wr_en   = commit;
   assign wr_addr = addr_q;
   assign wr_data = data_q;
   assign busy    = busy_q;

   // R7: a commit can only come from a capture taken while idle
   a_r7_commit_when_idle: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> !busy_q);

   // R5: every commit opens a busy window on the next edge
   a_r5_commit_opens_busy: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> busy_q);

   // R6: the window cannot close before its counter runs out
   a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
      (busy_q && wcnt_q != '0) |=> busy_q);

   // R9: a capture needs protect low at the deciding edge
   a_r9_arm_unprotected: assert property (@(posedge clk) disable iff (rst)
      $rose(armed_q) |-> !$past(wprot));

   // R10: no capture while the lockout window is open
   a_r10_arm_after_lock: assert property (@(posedge clk) disable iff (rst)
      armed_q |-> !lock_q);

   // R10: once the lockout ends it stays ended until reset
   a_r10_lock_stays_off: assert property (@(posedge clk) disable iff (rst)
      !lock_q |=> !lock_q);

endmodule

// File: rtl/attr_store_ctrl.sv
module attr_store_ctrl
   import attr_store_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int WR_CYCLES   = 500000,
   parameter int LOCK_CYCLES = 150000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_n,
   input  logic              ce1_n,
   input  logic              ce2_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              a0,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_en,
   input  logic              wprot,
   input  logic              ext_busy_n,
   output logic              rdy_bsy_n,
   output logic              rst_out_n
);

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("attr_store_ctrl: ADDR_W out of range 1..12");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("attr_store_ctrl: DATA_W must be positive");
   end

   strobe_t           raw_s, syn_s;
   logic [STB_W-1:0]  syn_bits;
   logic              ok, wr_active, wr_release, rd_act;
   logic              wr_en, busy;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data, arr_q;

   assign raw_s.reg_n = reg_n;
   assign raw_s.ce1_n = ce1_n;
   assign raw_s.ce2_n = ce2_n;
   assign raw_s.oe_n  = oe_n;
   assign raw_s.we_n  = we_n;
   assign raw_s.a0    = a0;

   attr_sync #(
      .WIDTH   (STB_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({STB_W{1'b1}})
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_s),
      .q   (syn_bits)
   );

   assign syn_s      = strobe_t'(syn_bits);
   assign ok         = lane_ok(syn_s);
   assign wr_active  = ok & ~syn_s.we_n;
   assign wr_release = syn_s.we_n | syn_s.ce1_n;
   assign rd_act     = ok & ~syn_s.oe_n;

   attr_write_ctrl #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .WR_CYCLES   (WR_CYCLES),
      .LOCK_CYCLES (LOCK_CYCLES)
   ) u_wctl (
      .clk        (clk),
      .rst        (rst),
      .wr_active  (wr_active),
      .wr_release (wr_release),
      .wprot      (wprot),
      .addr_i     (addr),
      .data_i     (wdata),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .busy       (busy)
   );

   attr_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_arr (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (addr),
      .rdata (arr_q)
   );

   assign rdata     = rd_act ? arr_q : '0;
   assign rdata_en  = rd_act;
   assign rdy_bsy_n = ext_busy_n & ~busy;
   assign rst_out_n = ~rst;

   // R1: the lane is never driven on the edge right after a reset cycle
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      rst |=> !rdata_en);

   // R6: a busy window holds the ready line low across the edge
   a_r6_ready_low_in_busy: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> !rdy_bsy_n);

endmodule

// File: tb/sim_attr_store_ctrl.sv
module sim_attr_store_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int WR   = 30;
   localparam int LOCK = 40;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       reg_n = 1, ce1_n = 1, ce2_n = 1, oe_n = 1, we_n = 1, a0 = 0;
   logic [7:0] addr = '0, wdata = '0;
   logic [7:0] rdata;
   logic       rdata_en, rdy_bsy_n, rst_out_n;
   logic       wprot = 0, ext_busy_n = 1;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [7:0] exp_mem [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   attr_store_ctrl #(
      .ADDR_W(8), .DATA_W(8), .SYNC_STAGES(2), .WR_CYCLES(WR), .LOCK_CYCLES(LOCK)
   ) u0 (
      .clk(clk), .rst(rst), .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
      .oe_n(oe_n), .we_n(we_n), .a0(a0), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rdata_en(rdata_en), .wprot(wprot),
      .ext_busy_n(ext_busy_n), .rdy_bsy_n(rdy_bsy_n), .rst_out_n(rst_out_n)
   );

   function automatic bit lane_valid(bit rg_n, bit av, bit c2_n);
      return !rg_n && !av && c2_n;
   endfunction

   function automatic bit write_takes(bit rg_n, bit av, bit c2_n, bit wp);
      return lane_valid(rg_n, av, c2_n) && !wp;
   endfunction

   task automatic chk(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic wait_neg(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Ends on the negedge where the controlling strobe rose.
   task automatic write_cycle(logic [7:0] adr, logic [7:0] dat, bit rg_n, bit av,
                              bit c2_n, bit by_ce, bit flip);
      @(negedge clk);
      addr = adr; wdata = dat; reg_n = rg_n; a0 = av; ce2_n = c2_n;
      @(negedge clk);
      ce1_n = 0; we_n = 0;
      wait_neg(6);
      if (flip) wdata = ~dat;
      wait_neg(2);
      @(negedge clk);
      if (by_ce) ce1_n = 1; else we_n = 1;
   endtask

   task automatic finish_bus();
      @(negedge clk);
      reg_n = 1; ce1_n = 1; ce2_n = 1; oe_n = 1; we_n = 1; a0 = 0;
   endtask

   task automatic read_cycle(logic [7:0] adr, bit rg_n, bit av, bit c2_n,
                             output logic en, output logic [7:0] d);
      @(negedge clk);
      addr = adr; reg_n = rg_n; a0 = av; ce2_n = c2_n; ce1_n = 0; oe_n = 0;
      wait_neg(4);
      en = rdata_en; d = rdata;
      finish_bus();
      wait_neg(3);
   endtask

   task automatic check_read(logic [7:0] adr, bit rg_n, bit av, bit c2_n, string req);
      logic en; logic [7:0] d;
      bit exp_en;
      read_cycle(adr, rg_n, av, c2_n, en, d);
      exp_en = lane_valid(rg_n, av, c2_n);
      chk(en == exp_en, req, en, exp_en);
      if (exp_en) chk(d == exp_mem[adr], req, d, exp_mem[adr]);
      else        chk(d == 8'h00, req, d, 0);
   endtask

   task automatic full_write(logic [7:0] adr, logic [7:0] dat, bit rg_n, bit av,
                             bit c2_n, bit by_ce);
      write_cycle(adr, dat, rg_n, av, c2_n, by_ce, 0);
      finish_bus();
      wait_neg(WR + 6);
      if (write_takes(rg_n, av, c2_n, wprot)) exp_mem[adr] = dat;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      logic en; logic [7:0] d;
      void'($urandom(32'h5eed_0a17));

      // Reset state (R11, R1)
      wait_neg(5);
      chk(rst_out_n == 0, "R11 rst_out_n in reset", rst_out_n, 0);
      chk(rdy_bsy_n == 1, "R11 ready in reset", rdy_bsy_n, 1);
      chk(rdata_en == 0, "R1 lane idle in reset", rdata_en, 0);
      rst = 0;
      @(negedge clk);
      chk(rst_out_n == 1, "R11 rst_out_n released", rst_out_n, 1);
      wait_neg(LOCK + 5);

      // Prefill every byte, alternating the terminating strobe (R5)
      for (int a = 0; a < 256; a++)
         full_write(8'(a), 8'(a) ^ 8'h5A, 0, 0, 1, a[0]);
      for (int a = 0; a < 256; a += 37)
         check_read(8'(a), 0, 0, 1, "R1 prefill readback");

      // R5/R6: busy window edges, write ended by we_n
      write_cycle(8'h21, 8'hC3, 0, 0, 1, 0, 0);
      finish_bus();
      wait_neg(2);
      chk(rdy_bsy_n == 0, "R5 busy starts", rdy_bsy_n, 0);
      wait_neg(WR - 1);
      chk(rdy_bsy_n == 0, "R6 busy last cycle", rdy_bsy_n, 0);
      @(negedge clk);
      chk(rdy_bsy_n == 1, "R6 busy ends", rdy_bsy_n, 1);
      exp_mem[8'h21] = 8'hC3;
      wait_neg(5);
      check_read(8'h21, 0, 0, 1, "R5 we-ended write");

      // R5: write ended by ce1_n
      write_cycle(8'h22, 8'h3C, 0, 0, 1, 1, 0);
      finish_bus();
      wait_neg(2);
      chk(rdy_bsy_n == 0, "R5 busy after ce1 rise", rdy_bsy_n, 0);
      wait_neg(WR + 6);
      exp_mem[8'h22] = 8'h3C;
      check_read(8'h22, 0, 0, 1, "R5 ce-ended write");

      // R4: data captured at pulse start
      write_cycle(8'h30, 8'h11, 0, 0, 1, 0, 1);
      finish_bus();
      wait_neg(WR + 6);
      exp_mem[8'h30] = 8'h11;
      check_read(8'h30, 0, 0, 1, "R4 leading-edge capture");

      // R7: second write inside busy is dropped
      write_cycle(8'h40, 8'h77, 0, 0, 1, 0, 0);
      finish_bus();
      wait_neg(3);
      write_cycle(8'h41, 8'h88, 0, 0, 1, 0, 0);
      finish_bus();
      wait_neg(WR + 6);
      exp_mem[8'h40] = 8'h77;
      check_read(8'h40, 0, 0, 1, "R7 first write kept");
      check_read(8'h41, 0, 0, 1, "R7 busy write ignored");

      // R9: write protect
      wprot = 1;
      write_cycle(8'h50, 8'h99, 0, 0, 1, 0, 0);
      finish_bus();
      wait_neg(2);
      chk(rdy_bsy_n == 1, "R9 no busy when protected", rdy_bsy_n, 1);
      wait_neg(WR + 4);
      wprot = 0;
      check_read(8'h50, 0, 0, 1, "R9 protected write ignored");

      // R2 / R3: wrong lane and wrong space
      full_write(8'h51, 8'hE1, 0, 1, 1, 0);
      check_read(8'h51, 0, 0, 1, "R2 odd write ignored");
      full_write(8'h52, 8'hE2, 0, 0, 0, 0);
      check_read(8'h52, 0, 0, 1, "R2 high-lane write ignored");
      full_write(8'h53, 8'hE3, 1, 0, 1, 0);
      check_read(8'h53, 0, 0, 1, "R3 common-space write ignored");
      check_read(8'h51, 0, 1, 1, "R2 odd read not driven");
      check_read(8'h52, 0, 0, 0, "R2 high-lane read not driven");
      check_read(8'h53, 1, 0, 1, "R3 common-space read not driven");

      // R8: external busy
      @(negedge clk);
      ext_busy_n = 0;
      #1 chk(rdy_bsy_n == 0, "R8 external busy", rdy_bsy_n, 0);
      @(negedge clk);
      ext_busy_n = 1;
      #1 chk(rdy_bsy_n == 1, "R8 external busy released", rdy_bsy_n, 1);

      // R11 / R10: reset during busy, retention, lockout
      write_cycle(8'h60, 8'hA5, 0, 0, 1, 0, 0);
      finish_bus();
      wait_neg(2);
      chk(rdy_bsy_n == 0, "R11 busy before reset", rdy_bsy_n, 0);
      exp_mem[8'h60] = 8'hA5;
      rst = 1;
      #1 chk(rst_out_n == 0, "R11 rst_out_n follows", rst_out_n, 0);
      wait_neg(2);
      chk(rdy_bsy_n == 1, "R11 reset clears busy", rdy_bsy_n, 1);
      rst = 0;
      write_cycle(8'h60, 8'h5A, 0, 0, 1, 0, 0);
      finish_bus();
      wait_neg(2);
      chk(rdy_bsy_n == 1, "R10 no busy in lockout", rdy_bsy_n, 1);
      wait_neg(LOCK + WR + 10);
      check_read(8'h60, 0, 0, 1, "R10 lockout write ignored, R11 retained");

      // Random mix
      for (int it = 0; it < 150; it++) begin
         logic [7:0] ra, rd;
         bit rg, av, c2, wpv;
         ra  = 8'($urandom_range(0, 255));
         rd  = 8'($urandom);
         rg  = ($urandom_range(0, 4) == 0);
         av  = ($urandom_range(0, 4) == 0);
         c2  = ($urandom_range(0, 4) != 0);
         wpv = ($urandom_range(0, 4) == 0);
         if ($urandom_range(0, 1) == 0) begin
            wprot = wpv;
            full_write(ra, rd, rg, av, c2, $urandom_range(0, 1) == 1);
            wprot = 0;
         end else begin
            check_read(ra, rg, av, c2, "R1 R2 R3 random read");
         end
      end
      for (int a = 0; a < 256; a += 17)
         check_read(8'(a), 0, 0, 1, "R1 final readback");

      en = 0; d = '0;
      done = 1;
      summary();
      $finish;
   end

endmodule